// File: doc/BRIEF.md
# Configuration Stream Loader

This block sits between a host word FIFO and the acquisition core of a logic analyser. It takes a stream of 16-bit words and turns it into the capture settings. The stream opens with a 32-bit start pattern. A run of records follows, each a header word and then its payload, and a 32-bit closing pattern ends it. Each header names a destination and the number of payload words. The scalar settings are collected in shadow storage. The live outputs take the new values only when a stream closes with every record present, so the core never sees a half-written configuration.

One record is long: the trigger-stage array. Its words are not held in the block. Each one goes straight out on a write port, with its word offset as the address, to a stage memory that the consumer owns. A malformed stream raises an error flag. The block then discards input until it sees the next start pattern.

Top module: `cfg_stream_loader`

## Requirements
- R1: After a synchronous active-high reset, every setting output is zero, and `done_o`, `err_o` and `trig_we_o` are low.
- R2: Words are ignored until two consecutive valid words equal 0xF5A5, which forms the 32-bit start value 0xF5A5F5A5 with its low half first. A single 0xF5A5 followed by any other word does not open a stream.
- R3: A header word carries the destination index in bits 15:8 and the payload length, in 16-bit words, in bits 7:0. A header is accepted only for index 0 (length 1), 1 (2), 3 (2), 5 (2), 7 (1), 8 (1) or 64 (length 10 × STAGES, 160 by default).
- R4: The 2-word records are assembled low word first. Index 1 loads `divider_o`, index 3 loads `scount_o` (kept as sent, in units of 16 samples) and index 5 loads `tpos_o`.
- R5: The 1-word records are stored unchanged. Index 0 loads `mode_o`, index 7 loads `tglb_o` and index 8 loads `chen_o`.
- R6: Each payload word of record 64 appears on `trig_wdata_o` with `trig_we_o` high one cycle after it is accepted. `trig_addr_o` is its offset in the record, starting at 0 and rising by one per word. The consumer reads the offsets as eight arrays of STAGES words (mask0, mask1, value0, value1, edge0, edge1, logic0, logic1), followed by 2·STAGES count words.
- R7: A stream is committed when, in the header position, two consecutive 0xFA5A words arrive (end value 0xFA5A FA5A) after all seven records have been seen. On commit, all six setting outputs change on the same edge and `done_o` is high for exactly that one cycle.
- R8: The setting outputs keep their values at every cycle other than a commit. This includes every word of an aborted stream.
- R9: A header with an unknown index, or with a length that does not match its index, sets `err_o`. The block returns to hunting for the start pattern, and the words that follow are ignored.
- R10: An end pattern that arrives before all seven records have been seen, or a first 0xFA5A not followed by a second, sets `err_o` and does not commit.
- R11: `err_o` stays high until the next start pattern is accepted, which clears it. `done_o` and `err_o` are never high together.
- R12: A record that appears more than once in a stream keeps the value of its last occurrence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word valid |
| in_word | input | 16 | Stream word |
| mode_o | output | 16 | Committed mode word |
| divider_o | output | 32 | Committed clock divider |
| scount_o | output | 32 | Committed sample count, in 16-sample units |
| tpos_o | output | 32 | Committed trigger position |
| tglb_o | output | 16 | Committed global trigger word |
| chen_o | output | 16 | Committed channel enable mask |
| trig_we_o | output | 1 | Trigger-stage memory write enable |
| trig_addr_o | output | 8 | Trigger-stage word offset |
| trig_wdata_o | output | 16 | Trigger-stage write data |
| done_o | output | 1 | One-cycle commit pulse |
| err_o | output | 1 | Stream error flag |

## Verification
The properties are checked on every cycle:
- the settings stay stable outside a commit;
- `done_o` is a single-cycle pulse and never coincides with `err_o`;
- a rising error always leaves the parser hunting;
- trigger writes stay in range, and back-to-back trigger writes have consecutive offsets.

Only the bench scenarios can show the rest:
- that each index lands in the right output with its words in the right order;
- that a repeated record keeps its last value;
- that stray words before a start pattern and words after a fault are ignored;
- that a short stream or a bad header leaves the old settings in place.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam logic [15:0] SYNC_OPEN_HALF  = 16'hF5A5;
    localparam logic [15:0] SYNC_CLOSE_HALF = 16'hFA5A;
    localparam int          N_REC           = 7;

    typedef enum logic [2:0] {
        REC_MODE = 3'd0,
        REC_DIV  = 3'd1,
        REC_SCNT = 3'd2,
        REC_TPOS = 3'd3,
        REC_TGLB = 3'd4,
        REC_CHEN = 3'd5,
        REC_TRIG = 3'd6,
        REC_NONE = 3'd7
    } rec_e;

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_HUNT2,
        PS_HDR,
        PS_BODY,
        PS_TAIL2
    } pstate_e;

    typedef struct packed {
        logic [15:0] mode;
        logic [31:0] divider;
        logic [31:0] scount;
        logic [31:0] tpos;
        logic [15:0] tglb;
        logic [15:0] chen;
    } cfg_set_t;

    function automatic rec_e rec_lookup(input logic [7:0] idx);
        case (idx)
            8'd0:    return REC_MODE;
            8'd1:    return REC_DIV;
            8'd3:    return REC_SCNT;
            8'd5:    return REC_TPOS;
            8'd7:    return REC_TGLB;
            8'd8:    return REC_CHEN;
            8'd64:   return REC_TRIG;
            default: return REC_NONE;
        endcase
    endfunction

    function automatic logic [7:0] rec_words(input rec_e r, input logic [7:0] trig_words);
        case (r)
            REC_MODE, REC_TGLB, REC_CHEN: return 8'd1;
            REC_DIV, REC_SCNT, REC_TPOS:  return 8'd2;
            REC_TRIG:                     return trig_words;
            default:                      return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfg_parse_fsm.sv
module cfg_parse_fsm
    import cfgld_pkg::*;
#(
    parameter int TRIG_WORDS = 160,
    parameter int TAW        = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           word_vld,
    input  logic [15:0]    word,
    output logic           ld_en,
    output rec_e           ld_rec,
    output logic           ld_hi,
    output logic [15:0]    ld_data,
    output logic           commit,
    output logic           trig_we,
    output logic [TAW-1:0] trig_addr,
    output logic [15:0]    trig_wdata,
    output logic           done,
    output logic           err
);

    localparam logic [7:0] TRIG_LEN8 = TRIG_WORDS[7:0];

    pstate_e          st_q;
    rec_e             rec_q;
    logic [7:0]       left_q;
    logic [7:0]       pos_q;
    logic [N_REC-1:0] seen_q;

    rec_e hdr_rec;
    logic hdr_ok;

    always_comb begin
        hdr_rec = rec_lookup(word[15:8]);
        hdr_ok  = (hdr_rec != REC_NONE) && (word[7:0] == rec_words(hdr_rec, TRIG_LEN8));
    end

    assign ld_en   = word_vld && (st_q == PS_BODY);
    assign ld_rec  = rec_q;
    assign ld_hi   = pos_q[0];
    assign ld_data = word;
    assign commit  = word_vld && (st_q == PS_TAIL2) && (word == SYNC_CLOSE_HALF) && (&seen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= PS_HUNT;
            rec_q      <= REC_NONE;
            left_q     <= '0;
            pos_q      <= '0;
            seen_q     <= '0;
            trig_we    <= 1'b0;
            trig_addr  <= '0;
            trig_wdata <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done    <= commit;
            trig_we <= 1'b0;
            if (word_vld) begin
                case (st_q)
                    PS_HUNT: begin
                        if (word == SYNC_OPEN_HALF) st_q <= PS_HUNT2;
                    end
                    PS_HUNT2: begin
                        if (word == SYNC_OPEN_HALF) begin
                            st_q   <= PS_HDR;
                            seen_q <= '0;
                            err    <= 1'b0;
                        end else begin
                            st_q <= PS_HUNT;
                        end
                    end
                    PS_HDR: begin
                        if (word == SYNC_CLOSE_HALF) begin
                            st_q <= PS_TAIL2;
                        end else if (hdr_ok) begin
                            st_q   <= PS_BODY;
                            rec_q  <= hdr_rec;
                            left_q <= word[7:0];
                            pos_q  <= '0;
                        end else begin
                            err  <= 1'b1;
                            st_q <= PS_HUNT;
                        end
                    end
                    PS_BODY: begin
                        if (rec_q == REC_TRIG) begin
                            trig_we    <= 1'b1;
                            trig_addr  <= pos_q[TAW-1:0];
                            trig_wdata <= word;
                        end
                        pos_q  <= pos_q + 8'd1;
                        left_q <= left_q - 8'd1;
                        if (left_q == 8'd1) begin
                            st_q          <= PS_HDR;
                            seen_q[rec_q] <= 1'b1;
                        end
                    end
                    PS_TAIL2: begin
                        st_q <= PS_HUNT;
                        if (!((word == SYNC_CLOSE_HALF) && (&seen_q))) err <= 1'b1;
                    end
                    default: st_q <= PS_HUNT;
                endcase
            end
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_err_apart: assert property (@(posedge clk) disable iff (rst)
        done |-> !err);

    a_r9_err_back_to_hunt: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (st_q == PS_HUNT));

    a_r6_addr_in_range: assert property (@(posedge clk) disable iff (rst)
        trig_we |-> (int'(trig_addr) < TRIG_WORDS));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (trig_we && $past(trig_we)) |-> (trig_addr == TAW'($past(trig_addr) + 1'b1)));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfgld_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  rec_e        ld_rec,
    input  logic        ld_hi,
    input  logic [15:0] ld_data,
    input  logic        commit,
    output cfg_set_t    live
);

    cfg_set_t sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            live <= '0;
        end else begin
            if (ld_en) begin
                case (ld_rec)
                    REC_MODE: sh_q.mode <= ld_data;
                    REC_TGLB: sh_q.tglb <= ld_data;
                    REC_CHEN: sh_q.chen <= ld_data;
                    REC_DIV:  if (ld_hi) sh_q.divider[31:16] <= ld_data;
                              else       sh_q.divider[15:0]  <= ld_data;
                    REC_SCNT: if (ld_hi) sh_q.scount[31:16]  <= ld_data;
                              else       sh_q.scount[15:0]   <= ld_data;
                    REC_TPOS: if (ld_hi) sh_q.tpos[31:16]    <= ld_data;
                              else       sh_q.tpos[15:0]     <= ld_data;
                    default: ;
                endcase
            end
            if (commit) live <= sh_q;
        end
    end

    a_r8_hold_until_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live));

endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
    import cfgld_pkg::*;
#(
    parameter int STAGES = 16,
    localparam int TRIG_WORDS = 10 * STAGES,
    localparam int TAW = $clog2(TRIG_WORDS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [15:0]    in_word,
    output logic [15:0]    mode_o,
    output logic [31:0]    divider_o,
    output logic [31:0]    scount_o,
    output logic [31:0]    tpos_o,
    output logic [15:0]    tglb_o,
    output logic [15:0]    chen_o,
    output logic           trig_we_o,
    output logic [TAW-1:0] trig_addr_o,
    output logic [15:0]    trig_wdata_o,
    output logic           done_o,
    output logic           err_o
);

    logic        ld_en;
    rec_e        ld_rec;
    logic        ld_hi;
    logic [15:0] ld_data;
    logic        commit;
    cfg_set_t    live;

    cfg_parse_fsm #(
        .TRIG_WORDS (TRIG_WORDS),
        .TAW        (TAW)
    ) u_parse (
        .clk        (clk),
        .rst        (rst),
        .word_vld   (in_vld),
        .word       (in_word),
        .ld_en      (ld_en),
        .ld_rec     (ld_rec),
        .ld_hi      (ld_hi),
        .ld_data    (ld_data),
        .commit     (commit),
        .trig_we    (trig_we_o),
        .trig_addr  (trig_addr_o),
        .trig_wdata (trig_wdata_o),
        .done       (done_o),
        .err        (err_o)
    );

    cfg_reg_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_rec  (ld_rec),
        .ld_hi   (ld_hi),
        .ld_data (ld_data),
        .commit  (commit),
        .live    (live)
    );

    assign mode_o    = live.mode;
    assign divider_o = live.divider;
    assign scount_o  = live.scount;
    assign tpos_o    = live.tpos;
    assign tglb_o    = live.tglb;
    assign chen_o    = live.chen;

endmodule

// File: tb/test_cfg_stream_loader.sv
`timescale 1ns/1ps
module test_cfg_stream_loader;

    localparam int TW = 160;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [15:0] in_word;
    logic [15:0] mode_o, tglb_o, chen_o, trig_wdata_o;
    logic [31:0] divider_o, scount_o, tpos_o;
    logic        trig_we_o, done_o, err_o;
    logic [7:0]  trig_addr_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] tmem [0:TW-1];

    always #4 clk = ~clk;

    cfg_stream_loader i_cfg_stream_loader (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
        .mode_o(mode_o), .divider_o(divider_o), .scount_o(scount_o),
        .tpos_o(tpos_o), .tglb_o(tglb_o), .chen_o(chen_o),
        .trig_we_o(trig_we_o), .trig_addr_o(trig_addr_o),
        .trig_wdata_o(trig_wdata_o), .done_o(done_o), .err_o(err_o)
    );

    always @(negedge clk) if (trig_we_o) tmem[trig_addr_o] = trig_wdata_o;

    // bit16 = header must be rejected, bits 15:0 = header word
    localparam logic [16:0] HDR_TAB [0:10] = '{
        {1'b0, 16'h0001}, {1'b0, 16'h0102}, {1'b0, 16'h0302}, {1'b0, 16'h0502},
        {1'b0, 16'h0701}, {1'b0, 16'h0801}, {1'b0, 16'h40A0}, {1'b1, 16'h0201},
        {1'b1, 16'h0002}, {1'b1, 16'h0103}, {1'b1, 16'h4001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        in_word = w;
        in_vld  = 1'b1;
        @(negedge clk);
        in_vld  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_sync();
        push(16'hF5A5); push(16'hF5A5);
    endtask

    task automatic rec16(input logic [7:0] idx, input logic [15:0] v);
        push({idx, 8'd1}); push(v);
    endtask

    task automatic rec32(input logic [7:0] idx, input logic [31:0] v, input bit gaps);
        push({idx, 8'd2}); if (gaps) idle(2);
        push(v[15:0]);     if (gaps) idle(1);
        push(v[31:16]);
    endtask

    task automatic rec_trig(input logic [15:0] seed, input bit gaps);
        push(16'h40A0);
        for (int k = 0; k < TW; k++) begin
            push(seed + 16'(k));
            if (gaps && (k % 7 == 3)) idle(1);
        end
    endtask

    task automatic chk_regs(input string req, input logic [15:0] m, input logic [31:0] d,
                            input logic [31:0] c, input logic [31:0] p,
                            input logic [15:0] g, input logic [15:0] e);
        chk({req, " mode"}, 32'(mode_o), 32'(m));
        chk({req, " divider"}, divider_o, d);
        chk({req, " count"}, scount_o, c);
        chk({req, " tpos"}, tpos_o, p);
        chk({req, " glb"}, 32'(tglb_o), 32'(g));
        chk({req, " chen"}, 32'(chen_o), 32'(e));
    endtask

    task automatic chk_trig(input string req, input logic [15:0] seed);
        int bad = 0;
        for (int k = 0; k < TW; k++) if (tmem[k] !== seed + 16'(k)) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < TW; k++) tmem[k] = 16'h0;
        rst = 1'b1; in_vld = 1'b0; in_word = 16'h0;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk_regs("R1", 16'h0, 32'h0, 32'h0, 32'h0, 16'h0, 16'h0);
        chk("R1 done", 32'(done_o), 0);
        chk("R1 err", 32'(err_o), 0);
        chk("R1 we", 32'(trig_we_o), 0);

        // header table walk: R3 accepted headers, R9 rejected ones, R10 short stream
        for (int i = 0; i < 11; i++) begin
            open_sync();
            chk("R11 err cleared by sync", 32'(err_o), 0);
            push(HDR_TAB[i][15:0]);
            if (HDR_TAB[i][16]) begin
                chk("R9 bad header", 32'(err_o), 1);
            end else begin
                chk("R3 good header", 32'(err_o), 0);
                for (int k = 0; k < int'(HDR_TAB[i][7:0]); k++) push(16'h5555);
                push(16'hFA5A);
                push(16'hFA5A);
                chk("R10 early end err", 32'(err_o), 1);
                chk("R10 no done", 32'(done_o), 0);
            end
        end
        chk_regs("R8 after rejects", 16'h0, 32'h0, 32'h0, 32'h0, 16'h0, 16'h0);

        // R2: stray words, lone open half, then a full stream
        push(16'h1234); push(16'hF5A5); push(16'h0001); push(16'h0001); push(16'hAAAA);
        open_sync();
        chk("R11 err cleared", 32'(err_o), 0);
        rec16(8'd0, 16'h1025);
        rec32(8'd1, 32'h0000_0004, 1'b0);
        rec32(8'd3, 32'h0010_0000, 1'b0);
        rec32(8'd5, 32'h0000_0400, 1'b0);
        rec16(8'd7, 16'h0031);
        rec16(8'd8, 16'h0007);
        rec_trig(16'hA000, 1'b0);
        push(16'hFA5A);
        chk("R8 before final word", 32'(mode_o), 32'h0);
        chk("R7 no early done", 32'(done_o), 0);
        push(16'hFA5A);
        chk("R7 done pulse", 32'(done_o), 1);
        chk_regs("R2 R4 R5 R7 commit", 16'h1025, 32'h0000_0004, 32'h0010_0000,
                 32'h0000_0400, 16'h0031, 16'h0007);
        chk_trig("R6 trig words", 16'hA000);
        idle(1);
        chk("R7 done one cycle", 32'(done_o), 0);
        chk("R11 no err", 32'(err_o), 0);

        // second stream: other order, gaps, repeated mode record (R12)
        open_sync();
        rec_trig(16'hB000, 1'b1);
        rec16(8'd8, 16'hFFFF);
        rec16(8'd0, 16'h0001);
        rec32(8'd5, 32'h1234_5678, 1'b1);
        rec32(8'd3, 32'hCAFE_0010, 1'b1);
        rec16(8'd7, 16'h0102);
        rec32(8'd1, 32'hDEAD_0001, 1'b1);
        idle(3);
        rec16(8'd0, 16'h2002);
        push(16'hFA5A); push(16'hFA5A);
        chk("R7 done 2", 32'(done_o), 1);
        chk_regs("R4 R5 R12 stream2", 16'h2002, 32'hDEAD_0001, 32'hCAFE_0010,
                 32'h1234_5678, 16'h0102, 16'hFFFF);
        chk_trig("R6 trig with gaps", 16'hB000);

        // aborted stream: unknown index mid-way, later words ignored (R8, R9)
        open_sync();
        rec16(8'd0, 16'h7777);
        rec32(8'd1, 32'h0BAD_0BAD, 1'b0);
        push(16'h0901);
        chk("R9 unknown index", 32'(err_o), 1);
        push(16'h0001); push(16'h4444);
        rec16(8'd7, 16'h0BAD);
        push(16'hFA5A); push(16'hFA5A);
        chk("R9 err held", 32'(err_o), 1);
        chk("R9 no done", 32'(done_o), 0);
        chk_regs("R8 after abort", 16'h2002, 32'hDEAD_0001, 32'hCAFE_0010,
                 32'h1234_5678, 16'h0102, 16'hFFFF);

        // incomplete stream, then lone close half followed by other word (R10)
        open_sync();
        rec16(8'd0, 16'h3333);
        rec16(8'd8, 16'h3333);
        push(16'hFA5A); push(16'hFA5A);
        chk("R10 missing records", 32'(err_o), 1);
        open_sync();
        push(16'hFA5A); push(16'h0000);
        chk("R10 broken end", 32'(err_o), 1);
        chk_regs("R8 after short", 16'h2002, 32'hDEAD_0001, 32'hCAFE_0010,
                 32'h1234_5678, 16'h0102, 16'hFFFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule